// File: doc/BRIEF.md
# Bucketed Receive Message Queue

This block is the receive side of one station on an on-chip message ring. A single shared store of message entries is split by configuration into up to eight independent circular queues, called buckets. Every arriving message names a bucket and carries the identity of the station that sent it. The message is appended to that bucket. A local consumer picks a bucket and removes its oldest entry. Each removal hands one credit back toward the original sender, so senders that respect their credit budget never overrun a bucket.

Bucket sizes are written through a small configuration port. Each bucket's region begins where the regions of all lower-numbered buckets end. A write is accepted only if the whole resulting layout is legal. A rejected write leaves the layout untouched and raises a sticky error flag. Each bucket reports whether it is empty or full, and how many entries it holds.

An accepted configuration write takes priority over a push or pop in the same cycle. That push or pop is discarded.

Top module: `ring_bucket_rxq`

## Requirements
- R1: After a synchronous active-low reset, every bucket has size 0 and holds nothing. So `bkt_empty` and `bkt_full` are all ones, every occupancy is 0, `overflow` and `cfg_error` are 0, and `out_valid` is 0.
- R2: A size write is accepted only if every bucket in the resulting layout meets three conditions: its size is zero or a power of two, and its start (the sum of the sizes of all lower-numbered buckets) is a multiple of its size; and the sizes together do not exceed DEPTH. An accepted write empties every bucket.
- R3: A write that breaks any condition of R2 leaves all sizes and contents unchanged and sets `cfg_error`. `cfg_error` stays set until reset.
- R4: A push to a bucket that has room stores the message and the sender ID in that bucket's region. Each bucket returns its entries in arrival order, independently of the other buckets.
- R5: A pop request to a non-empty bucket produces, one cycle later, `out_valid` high with the oldest entry on `out_data`. In the same cycle, `cred_src` holds that entry's sender ID and `cred_bkt` holds the bucket index.
- R6: A pop request to an empty bucket produces no `out_valid` and changes no occupancy.
- R7: A push to a full bucket or to a size-0 bucket is dropped, unless a pop of the same bucket is accepted in that cycle (R8). A dropped push sets `overflow`, which stays set until reset.
- R8: A push and an accepted pop of the same bucket in one cycle both take effect, including when the bucket is full. The occupancy is unchanged.
- R9: For each bucket, `bkt_count` equals the number of entries it holds. `bkt_empty` is set when that number is 0, and `bkt_full` is set when it equals the bucket size.
- R10: Head and tail wrap inside the bucket's own region. Traffic that wraps one bucket never disturbs the entries of another bucket.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Size write strobe |
| cfg_bkt | input | $clog2(NBKT) | Bucket whose size is written |
| cfg_size | input | $clog2(DEPTH+1) | New bucket size in entries |
| in_valid | input | 1 | Incoming message strobe |
| in_bkt | input | $clog2(NBKT) | Destination bucket of the incoming message |
| in_src | input | SRC_W | Sender station ID |
| in_data | input | DATA_W | Message payload |
| pop_req | input | 1 | Pop request from the local consumer |
| pop_bkt | input | $clog2(NBKT) | Bucket to pop |
| out_valid | output | 1 | Popped entry and credit valid |
| out_data | output | DATA_W | Popped payload |
| cred_src | output | SRC_W | Station that the credit goes back to |
| cred_bkt | output | $clog2(NBKT) | Bucket the credit belongs to |
| bkt_empty | output | NBKT | Per-bucket empty flags |
| bkt_full | output | NBKT | Per-bucket full flags |
| bkt_count | output | NBKT*$clog2(DEPTH+1) | Per-bucket occupancy, bucket 0 in the low slice |
| overflow | output | 1 | Sticky dropped-push flag |
| cfg_error | output | 1 | Sticky rejected-configuration flag |

## Verification
The bench builds the block with DEPTH=64, NBKT=8, DATA_W=16 and SRC_W=4. With a 64-entry store, a layout of 8, 8, 16 and 32 entries fills the store exactly. That lets the bench fill a bucket to full, push past it and wrap its pointers in a few dozen cycles. The same small sizes make both kinds of rejected layout easy to reach: a misaligned start, and a total beyond the store. Eight buckets keep several size-0 buckets available for probing dropped pushes and the full flag of an empty bucket.

// File: rtl/rbq_pkg.sv
// Package: shared helpers for the bucketed receive queue.
// Assumes: values passed in fit into 32 bits.
package rbq_pkg;

    // True when v is a nonzero power of two.
    function automatic logic is_pow2(input logic [31:0] v);
        return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
    endfunction

endpackage

// File: rtl/rbq_layout.sv
// Module: rbq_layout
// Derives each bucket's start offset from the current sizes, and judges
// whether a proposed size write leaves a legal layout: every size zero or a
// power of two, every start aligned to its size, and the total within DEPTH.
// Assumes: size_q always holds a layout that was legal when accepted.
module rbq_layout
    import rbq_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int NBKT  = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int SW   = $clog2(DEPTH + 1),
    localparam int BW   = $clog2(NBKT)
) (
    input  logic [NBKT-1:0][SW-1:0] size_q,
    input  logic [BW-1:0]           cfg_bkt,
    input  logic [SW-1:0]           cfg_size,
    output logic [NBKT-1:0][AW-1:0] start,
    output logic                    cfg_ok
);

    logic [NBKT-1:0][SW-1:0] cand;
    logic [31:0]             run_c;
    logic [31:0]             run_s;

    // Start offsets: running sum of the lower buckets' current sizes.
    always_comb begin
        run_s = 32'd0;
        for (int i = 0; i < NBKT; i++) begin
            start[i] = AW'(run_s);
            run_s    = run_s + 32'(size_q[i]);
        end
    end

    // Legality check of the layout the pending write would produce.
    always_comb begin
        cand          = size_q;
        cand[cfg_bkt] = cfg_size;
        cfg_ok        = 1'b1;
        run_c         = 32'd0;
        for (int i = 0; i < NBKT; i++) begin
            if (cand[i] != '0) begin
                if (!is_pow2(32'(cand[i])))
                    cfg_ok = 1'b0;
                if ((run_c & (32'(cand[i]) - 32'd1)) != 32'd0)
                    cfg_ok = 1'b0;
            end
            run_c = run_c + 32'(cand[i]);
        end
        if (run_c > 32'(DEPTH))
            cfg_ok = 1'b0;
    end

endmodule

// File: rtl/rbq_bucket_ctl.sv
// Module: rbq_bucket_ctl
// Head, tail and occupancy of one bucket. Pointers are offsets inside the
// bucket's region and wrap at its power-of-two size.
// Assumes: push is only asserted when there is room (or a pop coincides),
// pop only when the bucket holds an entry.
module rbq_bucket_ctl #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int SW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [SW-1:0] size,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] head,
    output logic [AW-1:0] tail,
    output logic [SW-1:0] count
);

    logic [SW-1:0] mask_w;
    logic [AW-1:0] mask;

    assign mask_w = size - SW'(1);
    assign mask   = mask_w[AW-1:0];

    // Pointer and occupancy update with wrap inside the region.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push)
                tail <= (tail + AW'(1)) & mask;
            if (pop)
                head <= (head + AW'(1)) & mask;
            if (push && !pop)
                count <= count + SW'(1);
            else if (pop && !push)
                count <= count - SW'(1);
        end
    end

endmodule

// File: rtl/rbq_store.sv
// Module: rbq_store
// Shared entry storage: one write port, one registered read port.
// A read and a write to the same address in one cycle return the old entry.
// Assumes: the controller keeps the two addresses apart unless that is wanted.
module rbq_store #(
    parameter int DEPTH = 256,
    parameter int EW    = 37,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [EW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [EW-1:0] rdata
);

    logic [EW-1:0] mem [DEPTH];

    // Write of incoming entries and registered read of popped entries.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        if (re)
            rdata <= mem[raddr];
    end

endmodule

// File: rtl/ring_bucket_rxq.sv
// Module: ring_bucket_rxq (top)
// Receive station queue: shared storage carved into software-sized buckets,
// per-bucket FIFO order, pop with credit return to the original sender.
// Assumes: the consumer only uses out_* and cred_* in the cycle out_valid is high.
module ring_bucket_rxq #(
    parameter int DEPTH  = 256,
    parameter int NBKT   = 8,
    parameter int DATA_W = 32,
    parameter int SRC_W  = 5,
    localparam int AW    = $clog2(DEPTH),
    localparam int SW    = $clog2(DEPTH + 1),
    localparam int BW    = $clog2(NBKT),
    localparam int EW    = DATA_W + SRC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [BW-1:0]        cfg_bkt,
    input  logic [SW-1:0]        cfg_size,
    input  logic                 in_valid,
    input  logic [BW-1:0]        in_bkt,
    input  logic [SRC_W-1:0]     in_src,
    input  logic [DATA_W-1:0]    in_data,
    input  logic                 pop_req,
    input  logic [BW-1:0]        pop_bkt,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_data,
    output logic [SRC_W-1:0]     cred_src,
    output logic [BW-1:0]        cred_bkt,
    output logic [NBKT-1:0]      bkt_empty,
    output logic [NBKT-1:0]      bkt_full,
    output logic [NBKT*SW-1:0]   bkt_count,
    output logic                 overflow,
    output logic                 cfg_error
);

    logic [NBKT-1:0][SW-1:0] size_q;
    logic [NBKT-1:0][AW-1:0] start;
    logic [AW-1:0]           head [NBKT];
    logic [AW-1:0]           tail [NBKT];
    logic [SW-1:0]           count [NBKT];
    logic                    cfg_ok;
    logic                    cfg_apply;
    logic                    pop_ok;
    logic                    push_ok;
    logic                    same_bkt;
    logic [EW-1:0]           rdata;

    rbq_layout #(.DEPTH(DEPTH), .NBKT(NBKT)) u_layout (
        .size_q   (size_q),
        .cfg_bkt  (cfg_bkt),
        .cfg_size (cfg_size),
        .start    (start),
        .cfg_ok   (cfg_ok)
    );

    assign cfg_apply = cfg_we && cfg_ok;
    assign pop_ok    = pop_req && !cfg_apply && (count[pop_bkt] != '0);
    assign same_bkt  = pop_ok && (pop_bkt == in_bkt);
    assign push_ok   = in_valid && !cfg_apply && (size_q[in_bkt] != '0)
                       && ((count[in_bkt] != size_q[in_bkt]) || same_bkt);

    // Bucket sizes and sticky configuration error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q    <= '0;
            cfg_error <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_ok)
                size_q[cfg_bkt] <= cfg_size;
            else
                cfg_error <= 1'b1;
        end
    end

    // Sticky flag for pushes that found no room.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overflow <= 1'b0;
        else if (in_valid && !cfg_apply && !push_ok)
            overflow <= 1'b1;
    end

    for (genvar i = 0; i < NBKT; i++) begin : g_bkt
        rbq_bucket_ctl #(.DEPTH(DEPTH)) u_ctl (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cfg_apply),
            .size  (size_q[i]),
            .push  (push_ok && (in_bkt == BW'(i))),
            .pop   (pop_ok && (pop_bkt == BW'(i))),
            .head  (head[i]),
            .tail  (tail[i]),
            .count (count[i])
        );
        assign bkt_empty[i]            = (count[i] == '0);
        assign bkt_full[i]             = (count[i] == size_q[i]);
        assign bkt_count[i*SW +: SW]   = count[i];
    end

    rbq_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
        .clk   (clk),
        .we    (push_ok),
        .waddr (start[in_bkt] + tail[in_bkt]),
        .wdata ({in_src, in_data}),
        .re    (pop_ok),
        .raddr (start[pop_bkt] + head[pop_bkt]),
        .rdata (rdata)
    );

    // Output strobe and credit bucket, aligned with the registered read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            cred_bkt  <= '0;
        end else begin
            out_valid <= pop_ok;
            if (pop_ok)
                cred_bkt <= pop_bkt;
        end
    end

    assign out_data = rdata[DATA_W-1:0];
    assign cred_src = rdata[EW-1:DATA_W];

endmodule

// File: rtl/rbq_checker.sv
// Module: rbq_checker
// Temporal properties of the bucketed receive queue, seen at its ports.
// Assumes: reset is held for at least two clock edges at start.
module rbq_checker #(
    parameter int NBKT = 8,
    parameter int SW   = 9,
    localparam int BW  = $clog2(NBKT)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic               in_valid,
    input logic [BW-1:0]      in_bkt,
    input logic               pop_req,
    input logic [BW-1:0]      pop_bkt,
    input logic               out_valid,
    input logic [NBKT-1:0]    bkt_empty,
    input logic [NBKT-1:0]    bkt_full,
    input logic [NBKT*SW-1:0] bkt_count,
    input logic               overflow,
    input logic               cfg_error
);

    // R5: a pop of a non-empty bucket yields an entry next cycle.
    a_r5_pop_yields_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !cfg_we && !bkt_empty[pop_bkt]) |=> out_valid);

    // R6: popping an empty bucket yields nothing.
    a_r6_no_pop_from_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && bkt_empty[pop_bkt]) |=> !out_valid);

    // R7: a push into a full bucket without a matching pop raises overflow.
    a_r7_full_push_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg_we && bkt_full[in_bkt]
         && !(pop_req && pop_bkt == in_bkt && !bkt_empty[in_bkt])) |=> overflow);

    // R7: overflow is sticky.
    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R3: configuration error is sticky.
    a_r3_cfg_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |=> cfg_error);

    // R9: outside configuration, each occupancy moves by at most one per cycle.
    for (genvar i = 0; i < NBKT; i++) begin : g_cnt
        a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_we |=> ((bkt_count[i*SW +: SW] == $past(bkt_count[i*SW +: SW]))
                      || (bkt_count[i*SW +: SW] == $past(bkt_count[i*SW +: SW]) + SW'(1))
                      || (bkt_count[i*SW +: SW] == $past(bkt_count[i*SW +: SW]) - SW'(1))));
    end

endmodule

bind ring_bucket_rxq rbq_checker #(.NBKT(NBKT), .SW(SW)) u_rbq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .in_valid  (in_valid),
    .in_bkt    (in_bkt),
    .pop_req   (pop_req),
    .pop_bkt   (pop_bkt),
    .out_valid (out_valid),
    .bkt_empty (bkt_empty),
    .bkt_full  (bkt_full),
    .bkt_count (bkt_count),
    .overflow  (overflow),
    .cfg_error (cfg_error)
);

// File: tb/test_ring_bucket_rxq.sv
module test_ring_bucket_rxq;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 64;
    localparam int NBKT   = 8;
    localparam int DATA_W = 16;
    localparam int SRC_W  = 4;
    localparam int SW     = $clog2(DEPTH + 1);
    localparam int BW     = $clog2(NBKT);
    localparam int NVEC   = 12;

    // Vector: [23] 1=push 0=pop, [22:20] bucket, [19:16] sender, [15:0] data.
    // For pops, sender and data are the expected values.
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b1, 3'd0, 4'd1, 16'h1111},
        {1'b1, 3'd2, 4'd2, 16'h2222},
        {1'b1, 3'd0, 4'd3, 16'h3333},
        {1'b1, 3'd3, 4'd4, 16'h4444},
        {1'b0, 3'd0, 4'd1, 16'h1111},
        {1'b1, 3'd2, 4'd5, 16'h5555},
        {1'b0, 3'd2, 4'd2, 16'h2222},
        {1'b0, 3'd0, 4'd3, 16'h3333},
        {1'b0, 3'd3, 4'd4, 16'h4444},
        {1'b1, 3'd1, 4'd6, 16'h6666},
        {1'b0, 3'd2, 4'd5, 16'h5555},
        {1'b0, 3'd1, 4'd6, 16'h6666}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic [BW-1:0]      cfg_bkt = '0;
    logic [SW-1:0]      cfg_size = '0;
    logic               in_valid = 1'b0;
    logic [BW-1:0]      in_bkt = '0;
    logic [SRC_W-1:0]   in_src = '0;
    logic [DATA_W-1:0]  in_data = '0;
    logic               pop_req = 1'b0;
    logic [BW-1:0]      pop_bkt = '0;
    logic               out_valid;
    logic [DATA_W-1:0]  out_data;
    logic [SRC_W-1:0]   cred_src;
    logic [BW-1:0]      cred_bkt;
    logic [NBKT-1:0]    bkt_empty;
    logic [NBKT-1:0]    bkt_full;
    logic [NBKT*SW-1:0] bkt_count;
    logic               overflow;
    logic               cfg_error;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ring_bucket_rxq #(.DEPTH(DEPTH), .NBKT(NBKT), .DATA_W(DATA_W), .SRC_W(SRC_W))
    i_ring_bucket_rxq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bkt(cfg_bkt), .cfg_size(cfg_size),
        .in_valid(in_valid), .in_bkt(in_bkt), .in_src(in_src), .in_data(in_data),
        .pop_req(pop_req), .pop_bkt(pop_bkt), .out_valid(out_valid), .out_data(out_data),
        .cred_src(cred_src), .cred_bkt(cred_bkt), .bkt_empty(bkt_empty), .bkt_full(bkt_full),
        .bkt_count(bkt_count), .overflow(overflow), .cfg_error(cfg_error)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] cnt(input int b);
        return bkt_count[b*SW +: SW];
    endfunction

    // One cycle of traffic, inputs driven and results sampled at falling edges.
    task automatic drive(input logic p, input logic [BW-1:0] pb, input logic [SRC_W-1:0] s,
                         input logic [DATA_W-1:0] d, input logic q, input logic [BW-1:0] qb);
        in_valid = p; in_bkt = pb; in_src = s; in_data = d;
        pop_req = q; pop_bkt = qb;
        @(negedge clk);
        in_valid = 1'b0; pop_req = 1'b0;
    endtask

    task automatic cfg(input logic [BW-1:0] b, input logic [SW-1:0] sz);
        cfg_we = 1'b1; cfg_bkt = b; cfg_size = sz;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pop_chk(input string req, input logic [BW-1:0] b,
                           input logic [SRC_W-1:0] es, input logic [DATA_W-1:0] ed);
        drive(1'b0, '0, '0, '0, 1'b1, b);
        chk(req, 32'(out_valid), 32'd1);
        chk(req, 32'(out_data), 32'(ed));
        chk(req, 32'(cred_src), 32'(es));
        chk(req, 32'(cred_bkt), 32'(b));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 empty", 32'(bkt_empty), 32'hFF);
        chk("R1 full", 32'(bkt_full), 32'hFF);
        chk("R1 count", 32'(bkt_count != '0), 32'd0);
        chk("R1 overflow", 32'(overflow), 32'd0);
        chk("R1 cfg_error", 32'(cfg_error), 32'd0);
        chk("R1 out_valid", 32'(out_valid), 32'd0);

        // R7: push into an unconfigured (size 0) bucket is dropped
        drive(1'b1, 3'd5, 4'd1, 16'hDEAD, 1'b0, '0);
        chk("R7 zero-size overflow", 32'(overflow), 32'd1);
        chk("R7 zero-size count", 32'(cnt(5)), 32'd0);
        do_reset();

        // R2: legal layout 8,8,16,32 fills the 64-entry store
        cfg(3'd0, 7'd8);
        cfg(3'd1, 7'd8);
        cfg(3'd2, 7'd16);
        cfg(3'd3, 7'd32);
        chk("R2 legal layout", 32'(cfg_error), 32'd0);
        chk("R2 full after sizing", 32'(bkt_full[3:0]), 32'd0);

        // R4/R5: vector walk of interleaved pushes and pops
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][23])
                drive(1'b1, VEC[v][22:20], VEC[v][19:16], VEC[v][15:0], 1'b0, '0);
            else
                pop_chk("R4 R5 vector pop", VEC[v][22:20], VEC[v][19:16], VEC[v][15:0]);
        end
        chk("R9 all empty after walk", 32'(bkt_empty[3:0]), 32'hF);

        // R10: entries parked in buckets 0 and 2 while bucket 1 wraps
        drive(1'b1, 3'd0, 4'd7, 16'hAAAA, 1'b0, '0);
        drive(1'b1, 3'd2, 4'd8, 16'hBBBB, 1'b0, '0);
        for (int i = 0; i < 8; i++)
            drive(1'b1, 3'd1, SRC_W'(i), DATA_W'(16'h0100 + i), 1'b0, '0);
        chk("R9 full at size", 32'(bkt_full[1]), 32'd1);
        chk("R9 count at size", 32'(cnt(1)), 32'd8);

        // R8: push and pop of a full bucket in one cycle
        drive(1'b1, 3'd1, 4'd9, 16'h01FF, 1'b1, 3'd1);
        chk("R8 popped oldest", 32'(out_data), 32'h0100);
        chk("R8 credit sender", 32'(cred_src), 32'd0);
        chk("R8 count unchanged", 32'(cnt(1)), 32'd8);
        chk("R8 no overflow", 32'(overflow), 32'd0);
        for (int i = 1; i < 8; i++)
            pop_chk("R10 wrapped order", 3'd1, SRC_W'(i), DATA_W'(16'h0100 + i));
        pop_chk("R8 late push kept", 3'd1, 4'd9, 16'h01FF);
        pop_chk("R10 neighbour b0 intact", 3'd0, 4'd7, 16'hAAAA);
        pop_chk("R10 neighbour b2 intact", 3'd2, 4'd8, 16'hBBBB);

        // R6: pop of an empty bucket
        drive(1'b0, '0, '0, '0, 1'b1, 3'd1);
        chk("R6 no out_valid", 32'(out_valid), 32'd0);
        chk("R6 count stays", 32'(cnt(1)), 32'd0);
        chk("R6 still empty", 32'(bkt_empty[1]), 32'd1);

        // R7: push past full is dropped
        for (int i = 0; i < 8; i++)
            drive(1'b1, 3'd0, 4'd2, DATA_W'(16'h0200 + i), 1'b0, '0);
        drive(1'b1, 3'd0, 4'd3, 16'h02FF, 1'b0, '0);
        chk("R7 overflow on full", 32'(overflow), 32'd1);
        chk("R7 count held", 32'(cnt(0)), 32'd8);
        for (int i = 0; i < 8; i++)
            pop_chk("R7 drained order", 3'd0, 4'd2, DATA_W'(16'h0200 + i));
        chk("R7 dropped entry absent", 32'(bkt_empty[0]), 32'd1);

        // R3: misaligned and oversized writes are rejected
        cfg(3'd1, 7'd16);
        chk("R3 misaligned flagged", 32'(cfg_error), 32'd1);
        for (int i = 0; i < 8; i++)
            drive(1'b1, 3'd1, 4'd1, DATA_W'(i), 1'b0, '0);
        chk("R3 size kept at 8", 32'(bkt_full[1]), 32'd1);
        cfg(3'd4, 7'd1);
        chk("R3 oversized ignored", 32'(bkt_full[4]), 32'd1);
        chk("R3 contents kept", 32'(cnt(1)), 32'd8);

        // R2: accepted write empties all buckets; error stays sticky
        cfg(3'd4, 7'd0);
        chk("R2 accepted write clears", 32'(cnt(1)), 32'd0);
        chk("R2 all empty", 32'(bkt_empty), 32'hFF);
        chk("R3 error sticky", 32'(cfg_error), 32'd1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule